// File: doc/BRIEF.md
# Chained Masked Bus Trigger

This block watches sampled words on a processor bus and compares each valid word against three programmable patterns. Each pattern is a value with a per-bit ignore mask, and a bit set in the mask always compares equal. When a trigger fires, the block flips that trigger's own event output. When the qualifying condition is met, it raises a halt request toward the core.

There are two modes. In independent mode every enabled trigger fires on any matching word, and any hit raises the halt request. In chained mode the triggers must hit in a fixed order: first, then second, then third. A trigger further down the chain is deaf until the one before it has hit. Only the hit on the last trigger raises the halt request. Software loads values, masks and the control word through a simple write port. It restarts the chain and drops the halt request by writing pulse bits in the control word.

Top module: `seq_bus_trigger`

## Requirements
- R1: On a cycle with `bus_valid_i` high, an enabled trigger k hits when `(bus_data_i ^ value_k) & ~mask_k` is all zeros. Bits set in mask_k never prevent a hit.
- R2: No trigger hits on a cycle where `bus_valid_i` is low, whatever the bus data.
- R3: A trigger whose enable bit is clear never hits.
- R4: In independent mode, a hit on trigger k inverts `evt_o[k]` at the clock edge that samples the bus word. Several triggers may invert their pins on the same edge.
- R5: In independent mode, any hit sets `halt_o` at the same edge.
- R6: In chained mode, trigger 1 is ignored until trigger 0 has hit, and trigger 2 is ignored until trigger 1 has hit.
- R7: In chained mode, one bus word advances the chain by at most one stage. A word matching triggers 0 and 1 on the cycle trigger 0 first hits fires only trigger 0.
- R8: In chained mode, only the hit on trigger 2 sets `halt_o`. After that hit the chain is done, and it ignores all words until it is restarted.
- R9: `halt_o` stays high until a control write with the halt-clear bit set. If a new halt hit arrives on the same edge, the hit wins.
- R10: A control write with the restart bit set returns the chain to waiting for trigger 0. This takes effect at the edge of the write.
- R11: After reset, `evt_o` and `halt_o` are low. All values, masks and enables are zero, the mode is independent, and the chain waits for trigger 0.
- R12: The register map is as follows. Address 2k holds value_k and address 2k+1 holds mask_k, for k = 0 to 2. Address 6 is the control word: bits 2:0 are the trigger enables, bit 3 selects chained mode, bit 4 is the restart pulse and bit 5 is the halt-clear pulse. A register write takes effect for bus words in later cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Bus word qualifier |
| bus_data_i | input | 64 | Sampled bus word |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 64 | Register write data |
| evt_o | output | 3 | Per-trigger event pins, inverted on each hit |
| halt_o | output | 1 | Halt request level |

## Verification
A bus word or write presented in one cycle affects `evt_o` and `halt_o` at the very next rising edge. The comparison path is combinational into the toggle and halt flops, so there is exactly one cycle of latency, and it is the same for every result. The driver presents each operation after a falling edge. At the following rising edge it pushes the outputs predicted by a reference model. The monitor pops and compares that prediction at the next falling edge, which is the first settled point after the edge where the result lands.

// File: rtl/seq_trig_pkg.sv
package seq_trig_pkg;
  localparam int unsigned BUS_W    = 64;
  localparam int unsigned NUM_TRIG = 3;
  localparam int unsigned ADDR_W   = 4;
endpackage

// File: rtl/seq_trig_regs.sv
module seq_trig_regs #(
  parameter int unsigned BUS_W    = 64,
  parameter int unsigned NUM_TRIG = 3,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_en_i,
  input  logic [ADDR_W-1:0]                  wr_addr_i,
  input  logic [BUS_W-1:0]                   wr_data_i,
  output logic [NUM_TRIG-1:0][BUS_W-1:0]     val_o,
  output logic [NUM_TRIG-1:0][BUS_W-1:0]     mask_o,
  output logic [NUM_TRIG-1:0]                en_o,
  output logic                               seq_o,
  output logic                               rearm_o,
  output logic                               halt_clr_o
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(2 * NUM_TRIG);
  localparam int unsigned SEQ_BIT   = NUM_TRIG;
  localparam int unsigned REARM_BIT = NUM_TRIG + 1;
  localparam int unsigned HCLR_BIT  = NUM_TRIG + 2;

  logic ctrl_wr;
  assign ctrl_wr = wr_en_i && (wr_addr_i == CTRL_ADDR);

  for (genvar k = 0; k < NUM_TRIG; k++) begin : g_pat
    localparam logic [ADDR_W-1:0] VAL_ADDR  = ADDR_W'(2 * k);
    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(2 * k + 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_o[k]  <= '0;
        mask_o[k] <= '0;
      end else if (wr_en_i) begin
        if (wr_addr_i == VAL_ADDR)  val_o[k]  <= wr_data_i;
        if (wr_addr_i == MASK_ADDR) mask_o[k] <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= '0;
      seq_o <= 1'b0;
    end else if (ctrl_wr) begin
      en_o  <= wr_data_i[NUM_TRIG-1:0];
      seq_o <= wr_data_i[SEQ_BIT];
    end
  end

  // Pulses act at the edge of the write itself
  assign rearm_o    = ctrl_wr && wr_data_i[REARM_BIT];
  assign halt_clr_o = ctrl_wr && wr_data_i[HCLR_BIT];
endmodule

// File: rtl/seq_trig_match.sv
module seq_trig_match #(
  parameter int unsigned BUS_W = 64
) (
  input  logic             valid_i,
  input  logic             en_i,
  input  logic [BUS_W-1:0] bus_i,
  input  logic [BUS_W-1:0] val_i,
  input  logic [BUS_W-1:0] mask_i,
  output logic             hit_o
);
  logic [BUS_W-1:0] diff;
  assign diff  = (bus_i ^ val_i) & ~mask_i;
  assign hit_o = valid_i && en_i && (diff == '0);
endmodule

// File: rtl/seq_trig_fsm.sv
module seq_trig_fsm #(
  parameter int unsigned NUM_TRIG = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TRIG-1:0] hit_i,
  input  logic                seq_i,
  input  logic                rearm_i,
  input  logic                halt_clr_i,
  output logic [NUM_TRIG-1:0] evt_o,
  output logic                halt_o
);
  localparam int unsigned STG_W = $clog2(NUM_TRIG + 1);

  logic [STG_W-1:0]    stage_q;
  logic [NUM_TRIG-1:0] fire;
  logic                halt_set;

  // Chained mode: only the stage being waited on may fire
  always_comb begin
    fire = '0;
    if (seq_i) begin
      for (int k = 0; k < NUM_TRIG; k++)
        if (stage_q == STG_W'(k) && hit_i[k]) fire[k] = 1'b1;
    end else begin
      fire = hit_i;
    end
  end

  assign halt_set = seq_i ? fire[NUM_TRIG-1] : |fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      evt_o   <= '0;
      halt_o  <= 1'b0;
    end else begin
      evt_o <= evt_o ^ fire;
      if (halt_set)        halt_o <= 1'b1;
      else if (halt_clr_i) halt_o <= 1'b0;
      if (rearm_i)               stage_q <= '0;
      else if (seq_i && |fire)   stage_q <= stage_q + 1'b1;
    end
  end
endmodule

// File: rtl/seq_bus_trigger.sv
module seq_bus_trigger
  import seq_trig_pkg::*;
#(
  parameter int unsigned P_BUS_W    = BUS_W,
  parameter int unsigned P_NUM_TRIG = NUM_TRIG,
  parameter int unsigned P_ADDR_W   = ADDR_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_valid_i,
  input  logic [P_BUS_W-1:0]    bus_data_i,
  input  logic                  wr_en_i,
  input  logic [P_ADDR_W-1:0]   wr_addr_i,
  input  logic [P_BUS_W-1:0]    wr_data_i,
  output logic [P_NUM_TRIG-1:0] evt_o,
  output logic                  halt_o
);
  logic [P_NUM_TRIG-1:0][P_BUS_W-1:0] val;
  logic [P_NUM_TRIG-1:0][P_BUS_W-1:0] mask;
  logic [P_NUM_TRIG-1:0]              en;
  logic [P_NUM_TRIG-1:0]              hit;
  logic                               seq_mode;
  logic                               rearm;
  logic                               halt_clr;

  seq_trig_regs #(
    .BUS_W(P_BUS_W), .NUM_TRIG(P_NUM_TRIG), .ADDR_W(P_ADDR_W)
  ) regs_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .val_o(val), .mask_o(mask), .en_o(en), .seq_o(seq_mode),
    .rearm_o(rearm), .halt_clr_o(halt_clr)
  );

  for (genvar k = 0; k < P_NUM_TRIG; k++) begin : g_cmp
    seq_trig_match #(.BUS_W(P_BUS_W)) match_i (
      .valid_i(bus_valid_i), .en_i(en[k]), .bus_i(bus_data_i),
      .val_i(val[k]), .mask_i(mask[k]), .hit_o(hit[k])
    );
  end

  seq_trig_fsm #(.NUM_TRIG(P_NUM_TRIG)) fsm_i (
    .clk_i, .rst_ni, .hit_i(hit), .seq_i(seq_mode),
    .rearm_i(rearm), .halt_clr_i(halt_clr),
    .evt_o, .halt_o
  );
endmodule

// File: rtl/seq_bus_trigger_chk.sv
module seq_bus_trigger_chk #(
  parameter int unsigned NT = 3,
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 64
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_valid_i,
  input logic          wr_en_i,
  input logic [AW-1:0] wr_addr_i,
  input logic [DW-1:0] wr_data_i,
  input logic [NT-1:0] evt_o,
  input logic          halt_o,
  input logic          seq_i
);
  logic clr_wr;
  assign clr_wr = wr_en_i && (wr_addr_i == AW'(2 * NT)) && wr_data_i[NT+2];

  assert_evt_needs_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o != $past(evt_o)) |-> $past(bus_valid_i));

  assert_one_stage_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(seq_i) |-> ($countones(evt_o ^ $past(evt_o)) <= 1));

  assert_halt_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(halt_o) && !$past(clr_wr)) |-> halt_o);

  assert_halt_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_o) |-> (evt_o != $past(evt_o)));

  assert_chain_halt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(seq_i) && $rose(halt_o)) |-> (evt_o[NT-1] != $past(evt_o[NT-1])));
endmodule

bind seq_bus_trigger seq_bus_trigger_chk #(
  .NT(P_NUM_TRIG), .AW(P_ADDR_W), .DW(P_BUS_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_valid_i(bus_valid_i),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
  .evt_o(evt_o), .halt_o(halt_o), .seq_i(seq_mode)
);

// File: tb/seq_bus_trigger_tb_top.sv
`timescale 1ns/1ps
module seq_bus_trigger_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic [63:0] bus_data = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [2:0]  evt;
  logic        halt;

  always #2.5 clk = ~clk;

  seq_bus_trigger dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(bus_valid), .bus_data_i(bus_data),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .evt_o(evt), .halt_o(halt)
  );

  int checks = 0;
  int fails  = 0;
  logic [3:0] exp_q[$];
  string      req_q[$];

  // Reference model
  logic [63:0] m_val[3];
  logic [63:0] m_mask[3];
  logic [2:0]  m_en = '0;
  logic        m_seq = 1'b0;
  int          m_stage = 0;
  logic [2:0]  m_evt = '0;
  logic        m_halt = 1'b0;

  localparam logic [63:0] VA = 64'h1111_2222_3333_4444;
  localparam logic [63:0] VB = 64'hAAAA_0000_5555_0000;
  localparam logic [63:0] VC = 64'h0F0F_F0F0_1234_5678;

  task automatic step(input logic v, input logic [63:0] d, input logic w,
                      input logic [3:0] a, input logic [63:0] wd, input string req);
    logic [2:0] hit, fire;
    logic       hset, hclr;
    @(negedge clk);
    bus_valid = v; bus_data = d; wr_en = w; wr_addr = a; wr_data = wd;
    for (int k = 0; k < 3; k++)
      hit[k] = v && m_en[k] && (((d ^ m_val[k]) & ~m_mask[k]) == 64'd0);
    fire = '0;
    if (m_seq) begin
      for (int k = 0; k < 3; k++) if (m_stage == k && hit[k]) fire[k] = 1'b1;
    end else fire = hit;
    hset = m_seq ? fire[2] : |fire;
    hclr = w && a == 4'd6 && wd[5];
    @(posedge clk);
    m_evt = m_evt ^ fire;
    if (hset) m_halt = 1'b1; else if (hclr) m_halt = 1'b0;
    if (w && a == 4'd6 && wd[4]) m_stage = 0;
    else if (m_seq && |fire) m_stage = m_stage + 1;
    if (w) begin
      if (a < 4'd6) begin
        if (a[0]) m_mask[a >> 1] = wd; else m_val[a >> 1] = wd;
      end else if (a == 4'd6) begin
        m_en = wd[2:0]; m_seq = wd[3];
      end
    end
    exp_q.push_back({m_evt, m_halt});
    req_q.push_back(req);
  endtask

  task automatic bus(input logic v, input logic [63:0] d, input string req);
    step(v, d, 1'b0, 4'd0, 64'd0, req);
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] wd, input string req);
    step(1'b0, 64'd0, 1'b1, a, wd, req);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      checks++;
      if ({evt, halt} !== e) begin
        fails++;
        $display("FAIL %s: evt/halt actual %b/%b expected %b/%b", r, evt, halt, e[3:1], e[0]);
      end
    end
  end

  bit finished = 1'b0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) begin m_val[k] = '0; m_mask[k] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (evt !== 3'b000 || halt !== 1'b0) begin
      fails++;
      $display("FAIL R11: evt/halt actual %b/%b expected 000/0", evt, halt);
    end
    bus(1'b1, 64'd0, "R11");                // zero regs but all disabled
    wr(4'd0, VA, "R12");
    wr(4'd1, 64'd0, "R12");
    wr(4'd6, 64'h1, "R12");                 // independent, trigger 0 enabled
    bus(1'b1, VA, "R4");                    // evt0 toggles, halt set (R5)
    bus(1'b0, VA, "R2");
    bus(1'b1, VA ^ 64'h1, "R1");            // one unmasked bit differs
    wr(4'd2, VB, "R12");
    wr(4'd3, 64'hFFFF_FFFF_0000_0000, "R12");
    wr(4'd6, 64'h7, "R12");
    bus(1'b1, {32'hDEAD_BEEF, VB[31:0]}, "R1");   // masked upper half
    bus(1'b1, {32'hDEAD_BEEF, VB[31:1], 1'b1}, "R1");
    wr(4'd4, VC, "R12");
    wr(4'd6, 64'h3, "R3");                  // trigger 2 disabled
    bus(1'b1, VC, "R3");
    bus(1'b1, 64'h5555, "R9");              // halt held
    wr(4'd6, 64'h27, "R9");                 // clear halt
    bus(1'b1, 64'h5555, "R9");
    bus(1'b1, VA, "R5");                    // halt set again
    wr(4'd6, 64'h27, "R9");
    wr(4'd2, VA, "R12");                    // trigger 1 also matches VA
    wr(4'd3, 64'd0, "R12");
    wr(4'd6, 64'h1F, "R10");                // chained, all enabled, restart
    bus(1'b1, VC, "R6");                    // trigger 2 not armed
    bus(1'b1, VA, "R7");                    // only trigger 0 fires
    bus(1'b1, VA, "R6");                    // now trigger 1 fires
    bus(1'b1, VA, "R8");                    // no halt from earlier stages
    bus(1'b1, VC, "R8");                    // trigger 2 fires, halt
    bus(1'b1, VA, "R8");                    // done, ignored
    bus(1'b1, VC, "R8");
    wr(4'd6, 64'h3F, "R10");                // restart and clear
    bus(1'b1, VA, "R10");                   // trigger 0 fires again
    bus(1'b1, VC, "R6");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule